// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block receives a reply from a contactless card. The reply carries no framing and no length field. The reader sends its own frame and then pulses `start_i`. The receiver waits a fixed number of timing ticks and then cuts the line into back-to-back bit windows of equal length. The input `rx_i` is the subcarrier after a hysteresis comparator has squared it up. The receiver synchronizes this input and counts every change of level within each window. A window with a count inside an open range (about 42 edges are typical for a carrier-modulated 1) becomes a 1. Silence, or a count that is too low or too high, becomes a 0.

The caller gives the number of bits it expects together with the start pulse. Requests above 16 are cut to 16. The bits are placed into the output word least significant bit first. When the last window closes, a one-cycle `done_o` strobe marks the word as complete. A reply of all zeros looks the same as no card at all, so the block reports no presence flag. Time advances only on cycles where `tick_i` is high, so any prescaled timebase can drive it.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset `done_o` and `busy_o` are 0 and `data_o` is 0. While the block is idle and no start arrives, `data_o` holds its value.
- R2: A start pulse makes `busy_o` high from the next cycle on. The first bit window begins WAIT_TICKS (490) ticks after the start. Input edges during this delay have no effect on the result.
- R3: Each bit window lasts BIT_TICKS (150) ticks, and the windows follow each other with no gap. Only cycles with `tick_i` high advance time.
- R4: Every level change of the synchronized input inside a window, rising or falling, adds one to that window's edge count.
- R5: A window decodes to 1 only when its edge count is strictly greater than LO_EDGES (20) and strictly less than HI_EDGES (60). The counts 20 and 60, and any count outside that range, give 0.
- R6: The bit from window k is placed at `data_o[k]`, so the first window is the least significant bit.
- R7: A requested bit count greater than 16 is treated as 16. Bits of `data_o` above the effective count read 0 when `done_o` is high.
- R8: A request of 0 bits raises `done_o` at the end of the start delay, with `data_o` equal to 0.
- R9: `done_o` is high for exactly one cycle, on the cycle after the tick that closes the last window. `busy_o` falls in that same cycle.
- R10: A start pulse while the block is busy abandons the reception in progress and begins a new one from the start delay.
- R11: The edge count saturates at HI_EDGES. A window with far more than HI_EDGES edges (for example 106) decodes to 0 and cannot wrap back into the valid range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable; one tick per high cycle |
| start_i | input | 1 | Reader frame finished; begin reception |
| nbits_i | input | 5 | Number of bits expected (capped at 16) |
| rx_i | input | 1 | Squared subcarrier level, asynchronous |
| data_o | output | 16 | Received word, first bit in bit 0 |
| done_o | output | 1 | One-cycle strobe: word complete |
| busy_o | output | 1 | Reception in progress |

## Verification
The bound checker tests a few things on every cycle. It checks that `done_o` never lasts more than one cycle and that `busy_o` falls together with it. It checks that a start always makes the block busy, that an idle word stays stable, and that no bit above the latched count is ever set at completion. The bench scenarios cover everything that depends on when edges arrive. These are the exact threshold counts, saturation with 106 edges, edges during the start delay being ignored, the least-significant-first ordering, the cap at 16 bits, and restart during a reception. For each, the bench compares the final word and the cycle of the `done_o` strobe with values it computes itself.

// File: rtl/sc_edge_rx_pkg.sv
package sc_edge_rx_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_BIT  = 2'd2
   } rx_phase_e;
endpackage

// File: rtl/sc_edge_rx_sync.sv
module sc_edge_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sc_edge_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= chain_q[STAGES-1];
   end

   assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/sc_edge_rx_timer.sv
module sc_edge_rx_timer
   import sc_edge_rx_pkg::*;
#(
   parameter int WAIT_TICKS = 490,
   parameter int BIT_TICKS  = 150
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic restart_i,
   input  logic halt_i,
   output logic wait_close_o,
   output logic win_close_o,
   output logic busy_o,
   output logic in_window_o
);
   localparam int LONGEST = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS;
   localparam int TW      = $clog2(LONGEST + 1);
   localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_TICKS - 1);
   localparam logic [TW-1:0] BIT_LAST  = TW'(BIT_TICKS - 1);

   rx_phase_e     phase_q;
   logic [TW-1:0] cnt_q;

   assign wait_close_o = (phase_q == PH_WAIT) && tick_i && (cnt_q == WAIT_LAST);
   assign win_close_o  = (phase_q == PH_BIT)  && tick_i && (cnt_q == BIT_LAST);
   assign busy_o       = (phase_q != PH_IDLE);
   assign in_window_o  = (phase_q == PH_BIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (restart_i) begin
         phase_q <= PH_WAIT;
         cnt_q   <= '0;
      end else if (halt_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (wait_close_o || win_close_o) begin
         phase_q <= PH_BIT;
         cnt_q   <= '0;
      end else if (tick_i && phase_q != PH_IDLE) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sc_edge_rx_count.sv
module sc_edge_rx_count #(
   parameter int LO_EDGES = 20,
   parameter int HI_EDGES = 60
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   input  logic edge_i,
   output logic bit_o
);
   localparam int CW = $clog2(HI_EDGES + 1);
   localparam logic [CW-1:0] SAT = CW'(HI_EDGES);
   localparam logic [CW-1:0] LO  = CW'(LO_EDGES);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_now;

   always_comb begin
      cnt_now = cnt_q;
      if (en_i && edge_i && cnt_q != SAT) cnt_now = cnt_q + 1'b1;
   end

   assign bit_o = (cnt_now > LO) && (cnt_now < SAT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_now;
   end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx #(
   parameter int MAX_BITS    = 16,
   parameter int REQ_W       = 5,
   parameter int WAIT_TICKS  = 490,
   parameter int BIT_TICKS   = 150,
   parameter int LO_EDGES    = 20,
   parameter int HI_EDGES    = 60,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                tick_i,
   input  logic                start_i,
   input  logic [REQ_W-1:0]    nbits_i,
   input  logic                rx_i,
   output logic [MAX_BITS-1:0] data_o,
   output logic                done_o,
   output logic                busy_o
);
   localparam int IW  = $clog2(MAX_BITS + 1);
   localparam int IXW = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

   generate
      if (HI_EDGES <= LO_EDGES + 1) begin : g_bad_range
         $error("sc_edge_rx: decision range is empty");
      end
      if (BIT_TICKS < 2 || WAIT_TICKS < 1) begin : g_bad_time
         $error("sc_edge_rx: timing parameters too small");
      end
      if ((1 << REQ_W) <= MAX_BITS) begin : g_bad_req
         $error("sc_edge_rx: REQ_W cannot express MAX_BITS");
      end
   endgenerate

   logic          edge_w, wait_close, win_close, in_window, bit_w, halt;
   logic [IW-1:0] cap_q, idx_q, cap_d;
   logic [MAX_BITS-1:0] data_q;
   logic          done_q;

   assign cap_d = (int'(nbits_i) > MAX_BITS) ? IW'(MAX_BITS) : IW'(nbits_i);

   assign halt = !start_i &&
                 ((wait_close && cap_q == '0) ||
                  (win_close && idx_q == cap_q - 1'b1));

   sc_edge_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_i),
      .edge_o (edge_w)
   );

   sc_edge_rx_timer #(.WAIT_TICKS(WAIT_TICKS), .BIT_TICKS(BIT_TICKS)) u_timer (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .restart_i    (start_i),
      .halt_i       (halt),
      .wait_close_o (wait_close),
      .win_close_o  (win_close),
      .busy_o       (busy_o),
      .in_window_o  (in_window)
   );

   sc_edge_rx_count #(.LO_EDGES(LO_EDGES), .HI_EDGES(HI_EDGES)) u_count (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i || wait_close || win_close),
      .en_i   (in_window),
      .edge_i (edge_w),
      .bit_o  (bit_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cap_q  <= '0;
         idx_q  <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else if (start_i) begin
         cap_q  <= cap_d;
         idx_q  <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= halt;
         if (win_close) begin
            data_q[idx_q[IXW-1:0]] <= bit_w;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign data_o = data_q;
   assign done_o = done_q;
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
   parameter int MAX_BITS = 16,
   parameter int REQ_W    = 5
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                start_i,
   input logic [REQ_W-1:0]    nbits_i,
   input logic [MAX_BITS-1:0] data_o,
   input logic                done_o,
   input logic                busy_o
);
   int cap_c;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cap_c <= 0;
      else if (start_i) cap_c <= (int'(nbits_i) > MAX_BITS) ? MAX_BITS : int'(nbits_i);
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R9
   busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o)));

   // R2
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o);

   // R7
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ((data_o >> cap_c) == '0));

   // R1
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> $stable(data_o));
endmodule

bind sc_edge_rx sc_edge_rx_chk #(.MAX_BITS(MAX_BITS), .REQ_W(REQ_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .nbits_i (nbits_i),
   .data_o  (data_o),
   .done_o  (done_o),
   .busy_o  (busy_o)
);

// File: tb/sc_edge_rx_bench.sv
module sc_edge_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WAITT = 490;
   localparam int BITT  = 150;
   localparam int NVEC  = 3;

   // vector: {nbits, per-window edge counts (byte k = window k), expected word}
   localparam int          VEC_N   [NVEC] = '{4, 6, 3};
   localparam logic [127:0] VEC_CNT[NVEC] = '{128'h2A2A002A,
                                              128'h6A003C3B1514,
                                              128'h1E3201};
   localparam logic [15:0] VEC_EXP [NVEC] = '{16'h000D, 16'h0006, 16'h0006};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        start = 1'b0;
   logic [4:0]  nbits = '0;
   logic        rx = 1'b0;
   logic [15:0] data;
   logic        done, busy;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_edge_rx u_sc_edge_rx (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .tick_i  (tick),
      .start_i (start),
      .nbits_i (nbits),
      .rx_i    (rx),
      .data_o  (data),
      .done_o  (done),
      .busy_o  (busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int n);
      @(negedge clk);
      nbits = 5'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Runs one reception; at return the strobe cycle has been checked.
   task automatic run_frame(input int n, input logic [127:0] cnts,
                            input logic [15:0] exp, input bit noise, input string req);
      int windows;
      int early;
      windows = (n > 16) ? 16 : n;
      early = 0;
      pulse_start(n);
      for (int w = 0; w < WAITT; w++) begin
         @(negedge clk);
         if (noise && w < 470 && (w % 3) == 1) rx = ~rx;   // R2 ignored edges
         if (w == 100) check("R2 busy", busy, 1);
         if (done && !(windows == 0 && w == WAITT-1)) early++;
      end
      for (int k = 0; k < windows; k++) begin
         int ne;
         ne = int'(cnts[8*k +: 8]);
         for (int i = 0; i < BITT; i++) begin
            @(negedge clk);
            if (i >= 10 && i < 10 + ne) rx = ~rx;
            if (done && !(k == windows-1 && i == BITT-1)) early++;
         end
      end
      check({req, " R10 no early done"}, early, 0);
      check({req, " R9 done"}, done, 1);
      check({req, " R9 busy low"}, busy, 0);
      check({req, " word"}, data, exp);
      @(negedge clk);
      check({req, " R9 one cycle"}, done, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 done", done, 0);
      check("R1 busy", busy, 0);
      check("R1 data", data, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle busy", busy, 0);
      check("R1 idle data", data, 0);

      // Table: R4 R5 R6 R11 boundaries and ordering
      for (int v = 0; v < NVEC; v++) begin
         run_frame(VEC_N[v], VEC_CNT[v], VEC_EXP[v], 1'b0, "R5 R6 R11 R3 table");
      end

      // R2 edges during the start delay are ignored
      run_frame(2, 128'h002A, 16'h0001, 1'b1, "R2 noisy wait");

      // R7 request above 16 is capped
      run_frame(20, {16{8'h2A}}, 16'hFFFF, 1'b0, "R7 cap");

      // R8 zero bits
      run_frame(0, 128'h0, 16'h0000, 1'b0, "R8 zero");

      // R1 word holds while idle
      repeat (20) @(negedge clk);
      check("R1 hold", data, 0);

      // R10 restart while busy
      pulse_start(3);
      repeat (300) @(negedge clk);
      check("R10 busy before restart", busy, 1);
      run_frame(2, 128'h002A, 16'h0001, 1'b0, "R10 restart");

      // R4 both edge directions: 41 toggles from a high start
      rx = 1'b1;
      repeat (5) @(negedge clk);
      run_frame(1, 128'h29, 16'h0001, 1'b0, "R4 odd count");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule